// File: doc/BRIEF.md
# Dual Spindle Motor Controller

This block keeps the run state and the speed setting of two disk spindle motors on behalf of a small controlling microcontroller. The microcontroller writes an 8-bit control word that carries, for each drive, a start level, a stop level, a select level and a ready level. It also writes a speed code onto a shared bus. A drive whose select level is high takes a copy of the shared code into its own speed register. The copy is made on every control write and on every speed bus write.

A motor is switched by its start and stop levels. Both levels low turn a stopped motor on. A high stop level turns a running motor off. Every other combination keeps the present state. The ready levels have no effect on either motor. They are stored and shown on a status output.

Each running motor drives a tachometer counter of programmable length. Every pass of that counter sets a per-drive flag. The microcontroller reads the flag with a one-cycle read strobe, and the read clears the flag. A motor that is off produces no tachometer events.

Top module: `spindle_pair_ctrl`

## Requirements
- R1: After reset both motors are off, both speed registers and the held shared code are zero, both tachometer flags are clear and both ready outputs are low. The stored control word is 0x0F, with start and stop high and select and ready low.
- R2: A control write in which a drive's start and stop bits are both 0 turns that motor on from the following clock edge. Drive 0 uses start bit 0 and stop bit 1. Drive 1 uses start bit 2 and stop bit 3.
- R3: A control write with a drive's stop bit at 1 turns that motor off from the following edge, whatever its start bit holds.
- R4: A control write with start at 1 and stop at 0 leaves the motor as it was. Cycles without a control write never change a motor.
- R5: A control write with a drive's select bit at 1 copies the shared speed code into that drive's speed register. The select bit is bit 5 for drive 0 and bit 4 for drive 1. If the speed bus is written in the same cycle, the new code is the one copied.
- R6: A speed bus write copies the new code into the speed register of every drive whose stored select bit is 1. The speed register of an unselected drive keeps its value.
- R7: A one-cycle read strobe on a drive's flag clears that flag at the next edge, when no tachometer event falls in the same cycle.
- R8: A running motor sets its flag TACH_PERIOD cycles after it turns on, and again every TACH_PERIOD cycles after that. A motor that is off never sets its flag.
- R9: When a tachometer event and a read of the same flag fall in the same cycle, the flag stays set.
- R10: Control bits 6 and 7 appear on ready[0] and ready[1] from the edge after the write. They do not affect either motor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word (start, stop, select, ready per drive) |
| spd_we | input | 1 | Shared speed bus write strobe |
| spd_wdata | input | SPD_W | Shared speed code |
| tach_rd | input | 2 | Per-drive tachometer flag read strobe |
| motor_on | output | 2 | Per-drive motor run state |
| speed_a | output | SPD_W | Drive 0 latched speed code |
| speed_b | output | SPD_W | Drive 1 latched speed code |
| tach_flag | output | 2 | Per-drive tachometer flag |
| ready | output | 2 | Stored ready levels |

## Verification
The bench targets the hold combination, where start is high and stop is low. A design that decoded the motor from the start bit alone would switch the motor off in that case. The bench writes a speed code with the select bit low and with the bus and the control port written in the same cycle. A design that used the old code, or copied without a select, would then show a wrong speed register. The bench counts the cycles from motor-on to the first flag and fires a read exactly in the cycle of the next tachometer event. An off-by-one counter or a read that wins over the event would leave the flag in the wrong state. It also keeps a stopped motor idle for several periods to catch stray events.

// File: rtl/spm_pkg.sv
package spm_pkg;

  typedef struct packed {
    logic start;
    logic stop;
    logic sel;
  } lane_ctl_t;

  localparam logic [7:0] CTL_RESET = 8'h0F;

  // Field positions of one drive inside the control word.
  function automatic lane_ctl_t lane_fields(input logic [7:0] w, input logic idx);
    lane_ctl_t r;
    if (idx == 1'b0) begin
      r.start = w[0];
      r.stop  = w[1];
      r.sel   = w[5];
    end else begin
      r.start = w[2];
      r.stop  = w[3];
      r.sel   = w[4];
    end
    return r;
  endfunction

  // Motor state after a control write.
  function automatic logic motor_next(input logic on, input logic start, input logic stop);
    logic r;
    r = on;
    if (!start && !stop && !on) r = 1'b1;
    else if (stop && on)        r = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/spm_ctl_reg.sv
module spm_ctl_reg
  import spm_pkg::*;
#(
  parameter int SPD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [7:0]       ctl_wdata,
  input  logic             spd_we,
  input  logic [SPD_W-1:0] spd_wdata,
  output logic [7:0]       ctl_eff,
  output logic [SPD_W-1:0] code_eff,
  output logic [1:0]       ready
);
  logic [7:0]       ctl_q;
  logic [SPD_W-1:0] code_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= CTL_RESET;
      code_q <= '0;
    end else begin
      if (ctl_we) ctl_q  <= ctl_wdata;
      if (spd_we) code_q <= spd_wdata;
    end
  end

  // Values seen by the lanes this cycle: a write takes effect at once.
  assign ctl_eff  = ctl_we ? ctl_wdata : ctl_q;
  assign code_eff = spd_we ? spd_wdata : code_q;
  assign ready    = ctl_q[7:6];
endmodule

// File: rtl/spm_lane.sv
module spm_lane
  import spm_pkg::*;
#(
  parameter int SPD_W       = 8,
  parameter int TACH_PERIOD = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic             cap_en,
  input  lane_ctl_t        fields,
  input  logic [SPD_W-1:0] code,
  input  logic             rd,
  output logic             motor_on,
  output logic [SPD_W-1:0] speed,
  output logic             tach_pulse,
  output logic             tach_flag
);
  localparam int CNT_W = (TACH_PERIOD > 1) ? $clog2(TACH_PERIOD) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TACH_PERIOD - 1);

  logic [CNT_W-1:0] cnt;

  assign tach_pulse = motor_on && (cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      motor_on <= 1'b0;
      speed    <= '0;
    end else begin
      if (ctl_we) motor_on <= motor_next(motor_on, fields.start, fields.stop);
      if (cap_en && fields.sel) speed <= code;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !motor_on) cnt <= '0;
    else if (cnt == CNT_LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          tach_flag <= 1'b0;
    else if (tach_pulse) tach_flag <= 1'b1;
    else if (rd)         tach_flag <= 1'b0;
  end
endmodule

// File: rtl/spindle_pair_ctrl.sv
module spindle_pair_ctrl
  import spm_pkg::*;
#(
  parameter int SPD_W       = 8,
  parameter int TACH_PERIOD = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [7:0]       ctl_wdata,
  input  logic             spd_we,
  input  logic [SPD_W-1:0] spd_wdata,
  input  logic [1:0]       tach_rd,
  output logic [1:0]       motor_on,
  output logic [SPD_W-1:0] speed_a,
  output logic [SPD_W-1:0] speed_b,
  output logic [1:0]       tach_flag,
  output logic [1:0]       ready
);
  localparam int N_DRV = 2;

  logic [7:0]       ctl_eff;
  logic [SPD_W-1:0] code_eff;
  logic             cap_en;
  logic [N_DRV-1:0] tach_pulse;
  logic [SPD_W-1:0] speed_arr [N_DRV];

  assign cap_en = ctl_we | spd_we;

  spm_ctl_reg #(.SPD_W(SPD_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .spd_we(spd_we), .spd_wdata(spd_wdata),
    .ctl_eff(ctl_eff), .code_eff(code_eff), .ready(ready)
  );

  for (genvar g = 0; g < N_DRV; g++) begin : g_lane
    spm_lane #(.SPD_W(SPD_W), .TACH_PERIOD(TACH_PERIOD)) u_lane (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .cap_en(cap_en),
      .fields(lane_fields(ctl_eff, 1'(g))), .code(code_eff), .rd(tach_rd[g]),
      .motor_on(motor_on[g]), .speed(speed_arr[g]),
      .tach_pulse(tach_pulse[g]), .tach_flag(tach_flag[g])
    );
  end

  assign speed_a = speed_arr[0];
  assign speed_b = speed_arr[1];
endmodule

// File: rtl/spm_checker.sv
module spm_checker #(
  parameter int SPD_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_we,
  input logic [7:0]       ctl_wdata,
  input logic             spd_we,
  input logic [SPD_W-1:0] spd_wdata,
  input logic [1:0]       tach_rd,
  input logic [1:0]       motor_on,
  input logic [SPD_W-1:0] speed_a,
  input logic [1:0]       tach_flag,
  input logic [1:0]       tach_pulse,
  input logic [1:0]       ready
);
  p_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && !ctl_wdata[0] && !ctl_wdata[1] |=> motor_on[0]);
  p_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && ctl_wdata[3] |=> !motor_on[1]);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> $stable(motor_on));
  p_same_cycle_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && ctl_wdata[5] && spd_we |=> speed_a == $past(spd_wdata));
  p_speed_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we && !spd_we |=> $stable(speed_a));
  p_rd_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tach_rd[0] && !tach_pulse[0] |=> !tach_flag[0]);
  p_no_pulse_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !motor_on[1] |-> !tach_pulse[1]);
  p_pulse_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tach_pulse[0] && tach_rd[0] |=> tach_flag[0]);
  p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> ready == $past(ctl_wdata[7:6]));
endmodule

bind spindle_pair_ctrl spm_checker #(.SPD_W(SPD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
  .spd_we(spd_we), .spd_wdata(spd_wdata), .tach_rd(tach_rd),
  .motor_on(motor_on), .speed_a(speed_a), .tach_flag(tach_flag),
  .tach_pulse(tach_pulse), .ready(ready)
);

// File: tb/tb_spindle_pair_ctrl.sv
module tb_spindle_pair_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SPD_W = 8;
  localparam int TP = 8;

  logic clk = 0, rst_n = 0;
  logic ctl_we = 0, spd_we = 0;
  logic [7:0] ctl_wdata = 0;
  logic [SPD_W-1:0] spd_wdata = 0;
  logic [1:0] tach_rd = 0;
  logic [1:0] motor_on, tach_flag, ready;
  logic [SPD_W-1:0] speed_a, speed_b;

  int total = 0, bad = 0;
  logic [1:0] m_on;
  logic [SPD_W-1:0] m_spd [2];
  logic [SPD_W-1:0] m_code;
  logic [7:0] m_ctl;

  always #(CLK_PERIOD/2) clk = ~clk;

  spindle_pair_ctrl #(.SPD_W(SPD_W), .TACH_PERIOD(TP)) dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .spd_we(spd_we), .spd_wdata(spd_wdata), .tach_rd(tach_rd),
    .motor_on(motor_on), .speed_a(speed_a), .speed_b(speed_b),
    .tach_flag(tach_flag), .ready(ready));

  function automatic logic exp_motor(logic on, logic st, logic sp);
    case ({sp, st})
      2'b00:   return 1'b1;
      2'b10,
      2'b11:   return 1'b0;
      default: return on;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One clock: drive, take the edge, settle.
  task automatic step(logic cw, logic [7:0] cd, logic sw, logic [7:0] sd, logic [1:0] rd);
    ctl_we = cw; ctl_wdata = cd; spd_we = sw; spd_wdata = sd; tach_rd = rd;
    @(posedge clk); #1;
    ctl_we = 0; spd_we = 0; tach_rd = 0;
    if (cw) begin
      m_on[0] = exp_motor(m_on[0], cd[0], cd[1]);
      m_on[1] = exp_motor(m_on[1], cd[2], cd[3]);
      m_ctl = cd;
    end
    if (sw) m_code = sd;
    if ((cw || sw) && m_ctl[5]) m_spd[0] = m_code;
    if ((cw || sw) && m_ctl[4]) m_spd[1] = m_code;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    m_on = 0; m_spd[0] = 0; m_spd[1] = 0; m_code = 0; m_ctl = 8'h0F;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk("R1 motor", motor_on, 0);
    chk("R1 speed_a", speed_a, 0);
    chk("R1 speed_b", speed_b, 0);
    chk("R1 flag", tach_flag, 0);
    chk("R1 ready", ready, 0);

    // R2 start drive 0 (bits 0,1 low); drive 1 stays idle
    step(1, 8'h0C, 0, 0, 0);
    chk("R2 drive0 on", motor_on, 2'b01);
    // R4 hold: start high, stop low
    step(1, 8'h0D, 0, 0, 0);
    chk("R4 hold on", motor_on, 2'b01);
    idle(2);
    chk("R4 no write", motor_on, 2'b01);
    // R3 stop drive 0 with start low too
    step(1, 8'h0E, 0, 0, 0);
    chk("R3 drive0 off", motor_on, 2'b00);
    step(1, 8'h0D, 0, 0, 0);
    chk("R4 hold off", motor_on, 2'b00);

    // R10 ready bits do not start motors
    step(1, 8'hCF, 0, 0, 0);
    chk("R10 ready", ready, 2'b11);
    chk("R10 motors", motor_on, 2'b00);

    // R6 speed bus write with no select
    step(0, 0, 1, 8'h5A, 0);
    chk("R6 unselected a", speed_a, 0);
    chk("R6 unselected b", speed_b, 0);
    // R5 select drive 1 (bit 4) copies held code
    step(1, 8'h1F, 0, 0, 0);
    chk("R5 copy b", speed_b, 8'h5A);
    chk("R5 a untouched", speed_a, 0);
    // R5 same-cycle code with drive 0 select (bit 5)
    step(1, 8'h2F, 1, 8'hC3, 0);
    chk("R5 same cycle a", speed_a, 8'hC3);
    chk("R5 b kept", speed_b, 8'h5A);
    // R6 bus write to selected drive
    step(0, 0, 1, 8'h77, 0);
    chk("R6 selected a", speed_a, 8'h77);
    chk("R6 deselected b", speed_b, 8'h5A);
    step(1, 8'h0F, 0, 0, 0);

    // R8 first event TP cycles after turning on drive 1
    step(1, 8'h03, 0, 0, 0);
    chk("R8 on", motor_on, 2'b10);
    idle(TP - 1);
    chk("R8 not yet", tach_flag, 2'b00);
    idle(1);
    chk("R8 first event", tach_flag, 2'b10);
    // R7 read clears
    step(0, 0, 0, 0, 2'b10);
    chk("R7 cleared", tach_flag, 2'b00);
    idle(TP - 2);
    // R9 read in the event cycle
    step(0, 0, 0, 0, 2'b10);
    chk("R9 event wins", tach_flag, 2'b10);
    // R8 off motor produces nothing
    step(1, 8'h0F, 0, 0, 2'b10);
    chk("R8 stop", motor_on, 2'b00);
    chk("R7 clear on stop", tach_flag, 2'b00);
    idle(3 * TP);
    chk("R8 no event off", tach_flag, 2'b00);

    // Random phase: motors, speeds, ready against the model
    for (int it = 0; it < 400; it++) begin
      logic cw, sw;
      logic [7:0] cd, sd;
      cw = ($urandom % 2) == 0;
      sw = ($urandom % 3) == 0;
      cd = 8'($urandom);
      sd = 8'($urandom);
      step(cw, cd, sw, sd, 0);
      chk("R2/R3/R4 random motor", motor_on, m_on);
      chk("R5/R6 random speed_a", speed_a, m_spd[0]);
      chk("R5/R6 random speed_b", speed_b, m_spd[1]);
      chk("R10 random ready", ready, m_ctl[7:6]);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule